// File: doc/BRIEF.md
# Multiplexed Host Port Slave

This block lets an external host processor read and write the 32-bit internal memory space of a chip over a narrow, multiplexed host bus. Two select pins pick which host-visible register a strobe reaches: a configuration register, an address register, or the data register. None of these registers has an address on the internal side. They exist only behind the select pins.

The host first loads an address. A later strobe to the data register then starts exactly one request on a simple synchronous memory port. A data write goes out as a single write request. A data read issues a read request and holds the host's ready line low until the memory returns its response. The returned word then stays in the data register, where the host picks it up.

Two configuration fields control how addresses work:
- The unit field decides whether a host address counts bytes or 32-bit words. Word addresses are scaled by four before they reach the memory port.
- The mode field decides whether one address write loads both the write-address and read-address registers, or whether a direction pin steers the address write to one of them.

Top module: `hpx_host_port`

## Requirements
- R1: After reset, `host_rdy` is 1 and `mem_req` is 0. A control read returns 0x00000002 (single-address mode on, word units). Both address registers and the data register read 0.
- R2: `host_sel` encoding: 00 selects the control register, 01 selects the address register, 10 selects the data register. Code 11 behaves exactly like 10 for both reads and writes.
- R3: When control bit 0 is 0 (word units), a data access drives `mem_addr` with the host address shifted left by two. For example, host address 0x10000000 yields 0x40000000.
- R4: When control bit 0 is 1 (byte units), a data access drives `mem_addr` with the host address unchanged.
- R5: When control bit 1 is 1 (single-address mode), one address write loads both address registers, whatever the value of `host_adir`.
- R6: When control bit 1 is 0 (dual-address mode), an address write with `host_adir`=0 loads only the write address, and one with `host_adir`=1 loads only the read address. Address reads return the register that `host_adir` picks.
- R7: An accepted data write produces `mem_req`=1 with `mem_we`=1 for exactly the cycle after the strobe. `mem_addr` carries the scaled write address and `mem_wdata` carries the host word. A later data read returns the host word.
- R8: An accepted data read produces `mem_req`=1 with `mem_we`=0 for the cycle after the strobe, at the scaled read address. `host_rdy` is 0 from that cycle through the cycle in which `mem_rvalid` is sampled 1, and 1 from the next cycle. From then on the data register returns `mem_rdata`.
- R9: A strobe while `host_rdy` is 0 is ignored. It causes no memory request and changes no register.
- R10: A control write with bit 31 set clears every configuration field to 0, whatever the other data bits hold.
- R11: Control and address writes never raise `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_cs | input | 1 | Host strobe, one cycle per access |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_sel | input | 2 | Register select (control/address/data) |
| host_adir | input | 1 | Address register pick in dual mode (0 write, 1 read) |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Selected register value |
| host_rdy | output | 1 | 0 while a data read waits for memory |
| mem_req | output | 1 | Memory request pulse |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write word |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response word |

## Verification
The hardest case to reach is a host strobe that lands while a read is still waiting on memory. The bench holds the read response back for several cycles and fires address writes and data strobes into that window. It then reads the address registers and watches the memory port to show that nothing moved. A second hard corner is the clear bit arriving together with nonzero field bits. The bench writes that combination after switching to byte units and dual-address mode, then shows that word scaling and single-register steering both return.

// File: rtl/hpx_pkg.sv
package hpx_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL     = 2'b00,
      SEL_ADDR     = 2'b01,
      SEL_DATA     = 2'b10,
      SEL_DATA_ALT = 2'b11
   } hsel_e;

   typedef struct packed {
      logic single_addr;
      logic byte_units;
   } cfg_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } xst_e;

   localparam cfg_t CFG_RST = '{single_addr: 1'b1, byte_units: 1'b0};

endpackage

// File: rtl/hpx_cfg_reg.sv
module hpx_cfg_reg
   import hpx_pkg::*;
#(
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_clear,
   input  logic [1:0]        wr_fields,
   output cfg_t              cfg_q,
   output logic [DATA_W-1:0] rd_word
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RST;
      end else if (wr_en) begin
         if (wr_clear) begin
            cfg_q <= '0;
         end else begin
            cfg_q.single_addr <= wr_fields[1];
            cfg_q.byte_units  <= wr_fields[0];
         end
      end
   end

   assign rd_word = DATA_W'({cfg_q.single_addr, cfg_q.byte_units});

endmodule

// File: rtl/hpx_addr_regs.sv
module hpx_addr_regs #(
   parameter int ADDR_W  = 32,
   parameter int SHIFT   = 2,
   parameter bit DUAL_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_val,
   input  logic              single_mode,
   input  logic              pick_rd,
   input  logic              byte_units,
   output logic [ADDR_W-1:0] rd_raw,
   output logic [ADDR_W-1:0] wr_byte_addr,
   output logic [ADDR_W-1:0] rd_byte_addr
);

   logic [ADDR_W-1:0] wa_q;
   logic [ADDR_W-1:0] ra_q;

   generate
      if (DUAL_EN) begin : g_dual
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wa_q <= '0;
               ra_q <= '0;
            end else if (wr_en) begin
               if (single_mode || !pick_rd) wa_q <= wr_val;
               if (single_mode ||  pick_rd) ra_q <= wr_val;
            end
         end
      end else begin : g_shared
         logic unused_pick;
         assign unused_pick = pick_rd ^ single_mode;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      wa_q <= '0;
            else if (wr_en)  wa_q <= wr_val;
         end
         assign ra_q = wa_q;
      end
   endgenerate

   function automatic logic [ADDR_W-1:0] to_byte(input logic [ADDR_W-1:0] a,
                                                 input logic bu);
      return bu ? a : (a << SHIFT);
   endfunction

   assign wr_byte_addr = to_byte(wa_q, byte_units);
   assign rd_byte_addr = to_byte(ra_q, byte_units);
   assign rd_raw       = pick_rd ? ra_q : wa_q;

endmodule

// File: rtl/hpx_xfer_ctl.sv
module hpx_xfer_ctl
   import hpx_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_we,
   input  logic [DATA_W-1:0] start_wdata,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              idle,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] data_q
);

   xst_e st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         mem_req   <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         data_q    <= '0;
      end else begin
         mem_req <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  mem_req <= 1'b1;
                  mem_we  <= start_we;
                  if (start_we) begin
                     mem_addr  <= wr_addr;
                     mem_wdata <= start_wdata;
                     data_q    <= start_wdata;
                  end else begin
                     mem_addr <= rd_addr;
                     st_q     <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: begin
               if (mem_rvalid) begin
                  data_q <= mem_rdata;
                  st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign idle = (st_q == ST_IDLE);

endmodule

// File: rtl/hpx_host_port.sv
module hpx_host_port
   import hpx_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int CLR_BIT = 31,
   parameter bit DUAL_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs,
   input  logic              host_we,
   input  logic [1:0]        host_sel,
   input  logic              host_adir,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rdy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int SHIFT = $clog2(DATA_W / 8);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_dw
         $error("hpx_host_port: DATA_W must be a multiple of 8, at least 16");
      end
      if (ADDR_W > DATA_W || ADDR_W <= SHIFT) begin : g_bad_aw
         $error("hpx_host_port: ADDR_W must fit the data word and exceed SHIFT");
      end
      if (CLR_BIT < 2 || CLR_BIT >= DATA_W) begin : g_bad_clr
         $error("hpx_host_port: CLR_BIT must lie above the config fields");
      end
   endgenerate

   cfg_t              cfg_q;
   logic [DATA_W-1:0] cfg_word;
   logic [ADDR_W-1:0] addr_raw;
   logic [ADDR_W-1:0] wr_byte_addr;
   logic [ADDR_W-1:0] rd_byte_addr;
   logic [DATA_W-1:0] data_q;
   logic              idle;
   logic              accept;
   logic              cfg_wr;
   logic              addr_wr;
   logic              data_go;
   logic              byte_units_w;

   assign accept  = host_cs && idle;
   assign cfg_wr  = accept && host_we && (host_sel == SEL_CTRL);
   assign addr_wr = accept && host_we && (host_sel == SEL_ADDR);
   assign data_go = host_cs && host_sel[1];

   hpx_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr),
      .wr_clear  (host_wdata[CLR_BIT]),
      .wr_fields (host_wdata[1:0]),
      .cfg_q     (cfg_q),
      .rd_word   (cfg_word)
   );

   assign byte_units_w = cfg_q.byte_units;

   hpx_addr_regs #(.ADDR_W(ADDR_W), .SHIFT(SHIFT), .DUAL_EN(DUAL_EN)) u_addr (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (addr_wr),
      .wr_val       (host_wdata[ADDR_W-1:0]),
      .single_mode  (cfg_q.single_addr),
      .pick_rd      (host_adir),
      .byte_units   (cfg_q.byte_units),
      .rd_raw       (addr_raw),
      .wr_byte_addr (wr_byte_addr),
      .rd_byte_addr (rd_byte_addr)
   );

   hpx_xfer_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (data_go),
      .start_we    (host_we),
      .start_wdata (host_wdata),
      .wr_addr     (wr_byte_addr),
      .rd_addr     (rd_byte_addr),
      .mem_rvalid  (mem_rvalid),
      .mem_rdata   (mem_rdata),
      .idle        (idle),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .data_q      (data_q)
   );

   always_comb begin
      unique case (host_sel)
         SEL_CTRL: host_rdata = cfg_word;
         SEL_ADDR: host_rdata = DATA_W'(addr_raw);
         default:  host_rdata = data_q;
      endcase
   end

   assign host_rdy = idle;

endmodule

// File: rtl/hpx_host_port_chk.sv
module hpx_host_port_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              host_cs,
   input logic              host_we,
   input logic [1:0]        host_sel,
   input logic [DATA_W-1:0] host_wdata,
   input logic              host_rdy,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_rvalid,
   input logic              byte_units
);

   AST_WR_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (host_cs && host_we && host_sel[1] && host_rdy)
      |=> (mem_req && mem_we && mem_wdata == $past(host_wdata))); // R7

   AST_RD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> !host_rdy); // R8

   AST_RDY_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_rdy) |-> $past(mem_rvalid)); // R8

   AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rdy |=> !mem_req); // R9

   AST_REG_WR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (host_cs && !host_sel[1]) |=> !mem_req); // R11

   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !byte_units) |-> (mem_addr[1:0] == 2'b00)); // R3

endmodule

bind hpx_host_port hpx_host_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_cs    (host_cs),
   .host_we    (host_we),
   .host_sel   (host_sel),
   .host_wdata (host_wdata),
   .host_rdy   (host_rdy),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_rvalid (mem_rvalid),
   .byte_units (byte_units_w)
);

// File: tb/hpx_host_port_test.sv
module hpx_host_port_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_cs = 1'b0;
   logic        host_we = 1'b0;
   logic [1:0]  host_sel = 2'b00;
   logic        host_adir = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_rdy;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   // behavioural reference state
   bit          m_byte = 1'b0;
   bit          m_single = 1'b1;
   int unsigned m_wa = 0;
   int unsigned m_ra = 0;
   int unsigned m_data = 0;
   bit          m_busy = 1'b0;
   bit          e_req = 1'b0;
   bit          e_we = 1'b0;
   int unsigned e_addr = 0;
   int unsigned e_wdata = 0;

   always #5 clk = ~clk;

   hpx_host_port uut (
      .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
      .host_sel(host_sel), .host_adir(host_adir), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_rdy(host_rdy), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
      end
   endtask

   function automatic int unsigned scale(int unsigned a);
      return m_byte ? a : (a << 2);
   endfunction

   function automatic int unsigned exp_rdata();
      if (host_sel == 2'b00) return {30'd0, m_single, m_byte};
      if (host_sel == 2'b01) return host_adir ? m_ra : m_wa;
      return m_data;
   endfunction

   // advance the model by one clock edge using the inputs now driven
   task automatic model_edge();
      e_req = 1'b0;
      if (m_busy) begin
         if (mem_rvalid) begin
            m_data = mem_rdata;
            m_busy = 1'b0;
         end
      end else if (host_cs) begin
         if (host_sel == 2'b00) begin
            if (host_we) begin
               if (host_wdata[31]) begin
                  m_byte = 1'b0; m_single = 1'b0;
               end else begin
                  m_byte = host_wdata[0]; m_single = host_wdata[1];
               end
            end
         end else if (host_sel == 2'b01) begin
            if (host_we) begin
               if (m_single || !host_adir) m_wa = host_wdata;
               if (m_single ||  host_adir) m_ra = host_wdata;
            end
         end else begin
            e_req = 1'b1;
            e_we  = host_we;
            if (host_we) begin
               e_addr = scale(m_wa); e_wdata = host_wdata; m_data = host_wdata;
            end else begin
               e_addr = scale(m_ra); m_busy = 1'b1;
            end
         end
      end
   endtask

   // one clock: model, edge, then compare every output at the falling edge
   task automatic step(string tag);
      model_edge();
      @(posedge clk);
      @(negedge clk);
      check(tag, "host_rdy", 32'(host_rdy), 32'(!m_busy));
      check(tag, "mem_req", 32'(mem_req), 32'(e_req));
      if (e_req) begin
         check(tag, "mem_we", 32'(mem_we), 32'(e_we));
         check(tag, "mem_addr", mem_addr, e_addr);
         if (e_we) check(tag, "mem_wdata", mem_wdata, e_wdata);
      end
      check(tag, "host_rdata", host_rdata, exp_rdata());
      host_cs = 1'b0;
      mem_rvalid = 1'b0;
   endtask

   task automatic hop(string tag, logic [1:0] sel, logic we, logic dir, logic [31:0] wd);
      host_cs = 1'b1; host_we = we; host_sel = sel; host_adir = dir; host_wdata = wd;
      step(tag);
   endtask

   task automatic peek(string tag, logic [1:0] sel, logic dir);
      host_sel = sel; host_adir = dir;
      step(tag);
   endtask

   task automatic respond(string tag, logic [31:0] d);
      mem_rvalid = 1'b1; mem_rdata = d;
      step(tag);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      peek("R1", 2'b00, 1'b0);
      peek("R1", 2'b01, 1'b0);
      peek("R1", 2'b01, 1'b1);
      peek("R1", 2'b10, 1'b0);

      // R3 word units, R5 single mode, R11 no request on register writes
      hop("R11", 2'b01, 1'b1, 1'b0, 32'h1000_0000);
      peek("R5", 2'b01, 1'b1);
      hop("R7", 2'b10, 1'b1, 1'b0, 32'hA5A5_0001);
      check("R3", "word scaled addr", mem_addr, 32'h4000_0000);
      peek("R7", 2'b10, 1'b0);

      // R8 read with a delayed response, R9 strobes during the stall
      hop("R2", 2'b11, 1'b0, 1'b0, 32'h0);
      hop("R9", 2'b01, 1'b1, 1'b0, 32'h0000_0BAD);
      hop("R9", 2'b10, 1'b1, 1'b0, 32'h1111_2222);
      hop("R9", 2'b00, 1'b1, 1'b0, 32'h0000_0001);
      peek("R8", 2'b10, 1'b0);
      respond("R8", 32'hDEAD_BEEF);
      peek("R8", 2'b10, 1'b0);
      peek("R2", 2'b11, 1'b0);
      peek("R9", 2'b01, 1'b0);
      peek("R9", 2'b00, 1'b0);

      // R4 byte units, R6 dual-address mode
      hop("R11", 2'b00, 1'b1, 1'b0, 32'h0000_0001);
      peek("R6", 2'b00, 1'b0);
      hop("R6", 2'b01, 1'b1, 1'b0, 32'h0000_0123);
      hop("R6", 2'b01, 1'b1, 1'b1, 32'h0000_0456);
      peek("R6", 2'b01, 1'b0);
      peek("R6", 2'b01, 1'b1);
      hop("R4", 2'b10, 1'b1, 1'b0, 32'h0BAD_F00D);
      check("R4", "byte addr", mem_addr, 32'h0000_0123);
      hop("R4", 2'b10, 1'b0, 1'b0, 32'h0);
      check("R6", "read addr", mem_addr, 32'h0000_0456);
      respond("R8", 32'h0000_7777);
      peek("R8", 2'b10, 1'b0);
      hop("R2", 2'b11, 1'b1, 1'b0, 32'h5555_AAAA);
      peek("R2", 2'b10, 1'b0);

      // R10 clear with field bits also set
      hop("R10", 2'b00, 1'b1, 1'b0, 32'h8000_0003);
      peek("R10", 2'b00, 1'b0);
      hop("R10", 2'b01, 1'b1, 1'b0, 32'h0000_0007);
      peek("R10", 2'b01, 1'b1);
      hop("R3", 2'b10, 1'b1, 1'b0, 32'hCAFE_0000);
      check("R3", "cleared word units", mem_addr, 32'h0000_001C);

      // back to single mode: R5 one write loads both
      hop("R5", 2'b00, 1'b1, 1'b0, 32'h0000_0002);
      hop("R5", 2'b01, 1'b1, 1'b1, 32'h0000_0040);
      peek("R5", 2'b01, 1'b0);
      peek("R5", 2'b01, 1'b1);
      hop("R5", 2'b10, 1'b0, 1'b0, 32'h0);
      check("R5", "shared read addr", mem_addr, 32'h0000_0100);
      respond("R8", 32'h0123_4567);
      peek("R8", 2'b10, 1'b0);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule